// File: doc/BRIEF.md
# Non-Volatile Array Power Reduction Controller

This block decides, cycle by cycle, whether a non-volatile memory array sits in its low-power state. It combines three triggers: a 2-bit policy that tells it how to react to system standby, explicit enter and leave command strobes, and array access requests. It drives the array's low-power enable, a status bit that mirrors that state, and a grant/stall pair on accesses. An access that finds the array asleep is stalled until the array has woken up.

The policy decides two things. The first is whether the system entering standby pushes the array into low power. The second is what brings the array back: the system leaving standby, or the first access. The real analog wake-up time is represented by a parameter, `WAKE_CYCLES`, which is the number of cycles the array spends waking before accesses are granted. A requester holds `acc_req` high until it sees `acc_grant`.

Top module: `nvm_lp_ctrl`

## Requirements
- R1: After synchronous reset the array is awake: `lp_en` and `lp_status` are 0, and an access request is granted in the same cycle.
- R2: Policy encoding is 0 = semi-automatic, 1 = fully automatic, 3 = manual. The unused value 2 behaves exactly like manual.
- R3: Semi-automatic (0): a rising edge of `standby` puts the array into low power from the next cycle. The first access while in low power starts the wake-up.
- R4: Fully automatic (1): a rising edge of `standby` puts the array into low power. An access during standby stalls and does not wake the array. In low power with `standby` low, the wake-up starts on the next edge and `lp_status` is 0 from the next cycle.
- R5: Manual (3, and 2): `standby` never puts the array into low power. The first access while in low power starts the wake-up.
- R6: Under every policy, `set_cmd` with `clr_cmd` low puts the array into low power on the next edge. This applies from the awake state and from the waking state.
- R7: `clr_cmd` from low power starts the wake-up, so `lp_status` is 0 from the next cycle. When `set_cmd` and `clr_cmd` arrive together, the clear wins and the array does not enter low power. `clr_cmd` has no effect while the array is awake.
- R8: `lp_en` and `lp_status` are 1 exactly while the array is in the low-power state. They are 0 while it is awake or waking.
- R9: `acc_grant` = `acc_req` while awake. Otherwise `acc_stall` = `acc_req`, and the two are never both 1. A request held from a cycle in low power is stalled for `WAKE_CYCLES`+1 cycles and granted in the next one.
- R10: Only the rising edge of `standby` counts. Standby held high after a wake-up does not put the array back to sleep. A rising edge during the waking phase under policy 0 or 1 returns the array to low power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | Power reduction policy (0 semi, 1 full, 3 manual, 2 as manual) |
| standby | input | 1 | System standby indicator |
| set_cmd | input | 1 | Enter low power command strobe |
| clr_cmd | input | 1 | Leave low power command strobe |
| acc_req | input | 1 | Array access request, held until granted |
| lp_en | output | 1 | Low-power enable to the array |
| lp_status | output | 1 | Status bit mirroring the low-power state |
| acc_grant | output | 1 | Access granted this cycle |
| acc_stall | output | 1 | Access stalled this cycle |

## Verification
The bench targets the exact stall length on a wake from low power. A design with an off-by-one timer would grant one cycle early or late. It also drives simultaneous set and clear commands, where a wrong priority would leave the array asleep. Standby held high after a wake-up under the semi-automatic policy catches a level-sensitive design, which would fall straight back to sleep. An access during standby under the fully automatic policy catches a design that lets accesses wake the array. Re-entry into low power during the waking phase, and reserved policy value 2, are also covered: a design that mishandled either would grant early or put the array to sleep on standby.

// File: rtl/nvm_lp_pkg.sv
package nvm_lp_pkg;

    typedef enum logic [1:0] {
        POL_SEMI   = 2'd0,
        POL_FULL   = 2'd1,
        POL_RSVD   = 2'd2,
        POL_MANUAL = 2'd3
    } pol_e;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_LOW    = 2'd1,
        ST_WAKE   = 2'd2
    } st_e;

    typedef struct packed {
        logic set;
        logic clr;
        logic stby;
        logic stby_rise;
        logic req;
    } ev_t;

    // Standby entry pushes the array to sleep only in the automatic policies.
    function automatic logic standby_sleeps(pol_e p);
        return (p == POL_SEMI) || (p == POL_FULL);
    endfunction

    // Leaving standby is the wake trigger only in fully automatic policy.
    function automatic logic standby_exit_wakes(pol_e p);
        return p == POL_FULL;
    endfunction

    // First access is the wake trigger in every other policy (reserved = manual).
    function automatic logic access_wakes(pol_e p);
        return p != POL_FULL;
    endfunction

endpackage

// File: rtl/nvm_lp_edge.sv
module nvm_lp_edge (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic din_q;

    always_ff @(posedge clk) begin
        if (rst) din_q <= 1'b0;
        else     din_q <= din;
    end

    assign rise = din & ~din_q;
endmodule

// File: rtl/nvm_lp_wake_timer.sv
module nvm_lp_wake_timer #(
    parameter int WAKE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WAKE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Counter sits at its reload value until the waking phase begins.
    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= RELOAD;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign done = run && (cnt == '0);
endmodule

// File: rtl/nvm_lp_fsm.sv
module nvm_lp_fsm
    import nvm_lp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] policy,
    input  ev_t        ev,
    input  logic       wake_done,
    output st_e        state
);
    pol_e pol;
    logic go_low;
    st_e  nxt;

    assign pol    = pol_e'(policy);
    // Clear beats set; standby entry only counts in automatic policies.
    assign go_low = !ev.clr && (ev.set || (ev.stby_rise && standby_sleeps(pol)));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ACTIVE: if (go_low) nxt = ST_LOW;
            ST_LOW: begin
                if (ev.clr
                    || (standby_exit_wakes(pol) && !ev.stby)
                    || (access_wakes(pol) && ev.req))
                    nxt = ST_WAKE;
            end
            ST_WAKE: begin
                if (go_low)         nxt = ST_LOW;
                else if (wake_done) nxt = ST_ACTIVE;
            end
            default: nxt = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ACTIVE;
        else     state <= nxt;
    end
endmodule

// File: rtl/nvm_lp_ctrl.sv
module nvm_lp_ctrl
    import nvm_lp_pkg::*;
#(
    parameter int WAKE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] policy,
    input  logic       standby,
    input  logic       set_cmd,
    input  logic       clr_cmd,
    input  logic       acc_req,
    output logic       lp_en,
    output logic       lp_status,
    output logic       acc_grant,
    output logic       acc_stall
);
    logic stby_rise;
    logic wake_done;
    ev_t  ev;
    st_e  state;

    nvm_lp_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (standby),
        .rise (stby_rise)
    );

    assign ev = '{set: set_cmd, clr: clr_cmd, stby: standby,
                  stby_rise: stby_rise, req: acc_req};

    nvm_lp_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_WAKE),
        .done (wake_done)
    );

    nvm_lp_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .policy    (policy),
        .ev        (ev),
        .wake_done (wake_done),
        .state     (state)
    );

    assign lp_en     = (state == ST_LOW);
    assign lp_status = lp_en;
    assign acc_grant = acc_req && (state == ST_ACTIVE);
    assign acc_stall = acc_req && (state != ST_ACTIVE);
endmodule

// File: rtl/nvm_lp_ctrl_chk.sv
module nvm_lp_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] policy,
    input logic       standby,
    input logic       set_cmd,
    input logic       clr_cmd,
    input logic       acc_req,
    input logic       lp_en,
    input logic       lp_status,
    input logic       acc_grant,
    input logic       acc_stall
);
    assert_grant_awake_R9: assert property (@(posedge clk) disable iff (rst)
        acc_grant |-> (!lp_en && !acc_stall));

    assert_req_served_R9: assert property (@(posedge clk) disable iff (rst)
        acc_req |-> (acc_grant ^ acc_stall));

    assert_set_enters_R6: assert property (@(posedge clk) disable iff (rst)
        (!lp_status && set_cmd && !clr_cmd) |=> lp_status);

    assert_clr_exits_R7: assert property (@(posedge clk) disable iff (rst)
        (lp_status && clr_cmd) |=> !lp_status);

    assert_manual_no_sleep_R5: assert property (@(posedge clk) disable iff (rst)
        (policy[1] && !lp_status && !set_cmd) |=> !lp_status);

    assert_full_wakes_R4: assert property (@(posedge clk) disable iff (rst)
        (policy == 2'd1 && lp_status && !standby) |=> !lp_status);

    assert_status_mirror_R8: assert property (@(posedge clk) disable iff (rst)
        lp_status |-> (lp_en && (acc_req ? acc_stall : 1'b1)));
endmodule

bind nvm_lp_ctrl nvm_lp_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .policy    (policy),
    .standby   (standby),
    .set_cmd   (set_cmd),
    .clr_cmd   (clr_cmd),
    .acc_req   (acc_req),
    .lp_en     (lp_en),
    .lp_status (lp_status),
    .acc_grant (acc_grant),
    .acc_stall (acc_stall)
);

// File: tb/nvm_lp_ctrl_tb.sv
module nvm_lp_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WAKE = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] policy = 2'd0;
    logic standby = 1'b0, set_cmd = 1'b0, clr_cmd = 1'b0, acc_req = 1'b0;
    logic lp_en, lp_status, acc_grant, acc_stall;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_lp_ctrl #(.WAKE_CYCLES(WAKE)) u_dut (
        .clk(clk), .rst(rst), .policy(policy), .standby(standby),
        .set_cmd(set_cmd), .clr_cmd(clr_cmd), .acc_req(acc_req),
        .lp_en(lp_en), .lp_status(lp_status),
        .acc_grant(acc_grant), .acc_stall(acc_stall)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: mode 0 awake, 1 asleep, 2 waking; wleft = waking cycles left.
    int mode = 0;
    int wleft = 0;
    bit prev_stby = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            mode = 0; wleft = 0; prev_stby = 1'b0;
        end else begin
            bit sleep_now;
            bit autop;
            autop = (policy == 2'd0) || (policy == 2'd1);
            sleep_now = !clr_cmd && (set_cmd || (standby && !prev_stby && autop));
            if (mode == 0) begin
                if (sleep_now) mode = 1;
            end else if (mode == 1) begin
                if (clr_cmd || (policy == 2'd1 && !standby) || (policy != 2'd1 && acc_req)) begin
                    mode = 2; wleft = WAKE;
                end
            end else begin
                if (sleep_now) mode = 1;
                else begin
                    wleft--;
                    if (wleft == 0) mode = 0;
                end
            end
            prev_stby = standby;
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(lp_status == (mode == 1), "R8 lp_status vs model", lp_status, mode == 1);
            chk(lp_en == (mode == 1), "R8 lp_en vs model", lp_en, mode == 1);
            chk(acc_grant == (acc_req && mode == 0), "R9 grant vs model", acc_grant, acc_req && mode == 0);
            chk(acc_stall == (acc_req && mode != 0), "R9 stall vs model", acc_stall, acc_req && mode != 0);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_grant(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (acc_grant || n > 50) break;
            n++;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        acc_req = 1'b1;
        @(negedge clk);
        chk(lp_status == 1'b0, "R1 status after reset", lp_status, 0);
        chk(acc_grant == 1'b1, "R1 grant after reset", acc_grant, 1);
        step(); acc_req = 1'b0;

        // R3 semi-automatic
        policy = 2'd0; standby = 1'b1; step();
        @(negedge clk);
        chk(lp_status == 1'b1, "R3 standby sleeps", lp_status, 1);
        step(); acc_req = 1'b1;
        wait_grant(n);
        chk(n == WAKE + 1, "R9 stall length from low", n, WAKE + 1);
        acc_req = 1'b0;
        repeat (3) step();
        @(negedge clk);
        chk(lp_status == 1'b0, "R10 held standby no resleep", lp_status, 0);
        step();

        // R4 fully automatic
        policy = 2'd1; standby = 1'b0; step();
        standby = 1'b1; step();
        @(negedge clk);
        chk(lp_status == 1'b1, "R4 standby sleeps", lp_status, 1);
        step(); acc_req = 1'b1;
        repeat (5) step();
        @(negedge clk);
        chk(lp_status == 1'b1 && acc_stall, "R4 access no wake", lp_status, 1);
        step(); acc_req = 1'b0; standby = 1'b0; step();
        @(negedge clk);
        chk(lp_status == 1'b0, "R4 standby exit wakes", lp_status, 0);
        step(); repeat (WAKE + 1) step();

        // R5 manual, R2 reserved
        policy = 2'd3; standby = 1'b1; step();
        @(negedge clk);
        chk(lp_status == 1'b0, "R5 manual ignores standby", lp_status, 0);
        step(); policy = 2'd2; standby = 1'b0; step();
        standby = 1'b1; step();
        @(negedge clk);
        chk(lp_status == 1'b0, "R2 reserved ignores standby", lp_status, 0);
        step(); acc_req = 1'b1;
        @(negedge clk);
        chk(acc_grant == 1'b1, "R5 awake grant", acc_grant, 1);
        step(); acc_req = 1'b0; standby = 1'b0;

        // R6 / R7 commands
        policy = 2'd3; set_cmd = 1'b1; step(); set_cmd = 1'b0;
        @(negedge clk);
        chk(lp_status == 1'b1, "R6 set enters", lp_status, 1);
        step(); clr_cmd = 1'b1; step(); clr_cmd = 1'b0;
        @(negedge clk);
        chk(lp_status == 1'b0, "R7 clear exits", lp_status, 0);
        step(); repeat (WAKE + 1) step();
        set_cmd = 1'b1; clr_cmd = 1'b1; step(); set_cmd = 1'b0; clr_cmd = 1'b0;
        @(negedge clk);
        chk(lp_status == 1'b0, "R7 clear wins over set", lp_status, 0);
        step(); clr_cmd = 1'b1; step(); clr_cmd = 1'b0; acc_req = 1'b1;
        @(negedge clk);
        chk(acc_grant == 1'b1, "R7 clear while awake no effect", acc_grant, 1);
        step(); acc_req = 1'b0;

        // R6 set during waking, then R9 length again
        set_cmd = 1'b1; step(); set_cmd = 1'b0; acc_req = 1'b1; step();
        @(negedge clk);
        chk(lp_status == 1'b0 && acc_stall, "R9 waking stalls", lp_status, 0);
        step(); set_cmd = 1'b1; step(); set_cmd = 1'b0;
        @(negedge clk);
        chk(lp_status == 1'b1, "R6 set during waking", lp_status, 1);
        step(); 
        wait_grant(n);
        chk(n == WAKE, "R9 remaining stall after re-entry", n, WAKE);
        acc_req = 1'b0;

        // R10 standby edge during waking
        policy = 2'd0; set_cmd = 1'b1; step(); set_cmd = 1'b0; acc_req = 1'b1; step();
        acc_req = 1'b0; standby = 1'b1; step();
        @(negedge clk);
        chk(lp_status == 1'b1, "R10 standby edge while waking", lp_status, 1);
        step(); standby = 1'b0; step();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule